// File: doc/BRIEF.md
# Selectable-Polynomial 24-bit CRC Engine

This block computes a 24-bit cyclic redundancy check over a bit-length message. The message arrives one byte per clock, most significant bit first. A final byte may be partial, with its valid bits packed at the top and a small count field saying how many there are. A select input picks one of three fixed 24-bit generator polynomials for each message.

The remainder register starts at zero for every message. It is neither preset to ones nor inverted at the end. When the byte flagged as last is accepted, the engine presents the 24-bit remainder on a registered output together with a one-cycle done strobe. It can take the first byte of the next message in the same cycle that the strobe is high. There is no back-pressure: a byte is accepted in every cycle where the valid input is high.

Top module: `crc24_multi_engine`

## Requirements
- R1: With `poly_sel` = 0 the generator is x^24+x^23+x^18+x^17+x^14+x^11+x^10+x^7+x^6+x^5+x^4+x^3+x+1 (24-bit tap word 0x864CFB). A message of the single bit 1 therefore yields 0x864CFB. `poly_sel` = 3 selects the same generator.
- R2: With `poly_sel` = 1 the generator is x^24+x^23+x^6+x^5+x+1 (tap word 0x800063).
- R3: With `poly_sel` = 2 the generator is x^24+x^23+x^21+x^20+x^17+x^15+x^13+x^12+x^8+x^4+x^2+x+1 (tap word 0xB2B117).
- R4: The remainder starts from zero with no final inversion, so a message made only of zero bits gives a CRC of 0x000000.
- R5: Bits enter MSB first. On a last byte with `in_nbits` = n (1..7), only bits 7 down to 8-n are used, and the remaining low bits have no effect on the result.
- R6: A last byte with `in_nbits` = 0 counts as a full eight bits.
- R7: On a byte that is not last, `in_nbits` is ignored and all eight bits are used.
- R8: `poly_sel` is sampled with the first byte of a message. Changes to it during later bytes of the same message do not alter the result.
- R9: `out_valid` is high for exactly the one cycle after the last byte is accepted, and `out_crc` holds its value until the next such cycle.
- R10: After reset `out_valid` is 0 and `out_crc` is 0. A new message may start in the cycle right after a last byte, and both messages are computed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_byte | input | 8 | Message byte, first bit in bit 7 |
| in_last | input | 1 | This byte ends the message |
| in_nbits | input | 3 | Valid bit count of a last byte, 0 meaning eight |
| poly_sel | input | 2 | Generator choice: 0 or 3 A, 1 B, 2 C |
| out_valid | output | 1 | One-cycle done strobe |
| out_crc | output | 24 | Remainder of the most recent message |

## Verification
The assertions take it that the inputs are free of X and that `in_valid` stays low while reset is held. The properties tying the done strobe to a past last byte rely on that low level in the cycle before reset is released. The bench drives all inputs on the falling edge and holds them at known values from time zero. It lowers `in_valid` during every reset and between messages, except in the run that sends two messages back to back on purpose.

// File: rtl/crc24_pkg.sv
package crc24_pkg;
  localparam int CRC_W = 24;
  localparam int SEL_W = 2;

  // Taps of each generator, x^23 in bit 23, x^24 implied
  localparam logic [CRC_W-1:0] TAPS_A = 24'h864CFB;
  localparam logic [CRC_W-1:0] TAPS_B = 24'h800063;
  localparam logic [CRC_W-1:0] TAPS_C = 24'hB2B117;

  typedef enum logic [SEL_W-1:0] {
    GEN_A     = 2'd0,
    GEN_B     = 2'd1,
    GEN_C     = 2'd2,
    GEN_A_ALT = 2'd3
  } gen_sel_e;
endpackage

// File: rtl/crc24_taps_rom.sv
module crc24_taps_rom
  import crc24_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output logic [CRC_W-1:0] taps
);
  always_comb begin
    unique case (gen_sel_e'(sel))
      GEN_B:   taps = TAPS_B;
      GEN_C:   taps = TAPS_C;
      default: taps = TAPS_A;
    endcase
  end
endmodule

// File: rtl/crc24_tail_count.sv
module crc24_tail_count #(
  parameter  int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTE_W)
) (
  input  logic             last,
  input  logic [CNT_W-1:0] nbits,
  output logic [CNT_W:0]   nuse
);
  // Only a last byte may be partial; a zero count means full width
  always_comb begin
    if (last && (nbits != '0)) nuse = {1'b0, nbits};
    else                       nuse = (CNT_W+1)'(BYTE_W);
  end
endmodule

// File: rtl/crc24_byte_step.sv
module crc24_byte_step
  import crc24_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTE_W)
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data,
  input  logic [CNT_W:0]    nuse,
  input  logic [CRC_W-1:0]  taps,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] stage [0:BYTE_W];
  assign stage[0] = crc_in;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
    logic             fb;
    logic [CRC_W-1:0] shifted;
    assign fb      = stage[k][CRC_W-1] ^ data[BYTE_W-1-k];
    assign shifted = {stage[k][CRC_W-2:0], 1'b0} ^ (fb ? taps : '0);
    // bits past the valid count pass the register through untouched
    assign stage[k+1] = ((CNT_W+1)'(k) < nuse) ? shifted : stage[k];
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/crc24_multi_engine.sv
module crc24_multi_engine
  import crc24_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_last,
  input  logic [CNT_W-1:0]  in_nbits,
  input  logic [SEL_W-1:0]  poly_sel,
  output logic              out_valid,
  output logic [CRC_W-1:0]  out_crc
);
  logic             msg_open;
  logic [SEL_W-1:0] sel_q;
  logic [CRC_W-1:0] crc_q;

  logic [SEL_W-1:0] sel_eff;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] taps;
  logic [CNT_W:0]   nuse;
  logic [CRC_W-1:0] crc_next;

  // first byte takes the live select and a zero register
  assign sel_eff  = msg_open ? sel_q : poly_sel;
  assign crc_base = msg_open ? crc_q : '0;

  crc24_taps_rom u_taps (
    .sel  (sel_eff),
    .taps (taps)
  );

  crc24_tail_count #(.BYTE_W(BYTE_W)) u_tail (
    .last  (in_last),
    .nbits (in_nbits),
    .nuse  (nuse)
  );

  crc24_byte_step #(.BYTE_W(BYTE_W)) u_step (
    .crc_in  (crc_base),
    .data    (in_byte),
    .nuse    (nuse),
    .taps    (taps),
    .crc_out (crc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_open  <= 1'b0;
      sel_q     <= '0;
      crc_q     <= '0;
      out_valid <= 1'b0;
      out_crc   <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        if (!msg_open) sel_q <= poly_sel;
        if (in_last) begin
          out_crc   <= crc_next;
          out_valid <= 1'b1;
          msg_open  <= 1'b0;
          crc_q     <= '0;
        end else begin
          crc_q    <= crc_next;
          msg_open <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crc24_multi_engine_chk.sv
module crc24_multi_engine_chk
  import crc24_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_byte,
  input logic              in_last,
  input logic              out_valid,
  input logic [CRC_W-1:0]  out_crc,
  input logic              msg_open
);
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> out_valid);

  p_done_needs_last_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_last));

  p_crc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_last) |=> $stable(out_crc));

  p_msg_closes_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> !msg_open);

  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && (out_crc == '0) && !msg_open));

  p_zero_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last && !msg_open && (in_byte == '0)) |=> (out_crc == '0));
endmodule

bind crc24_multi_engine crc24_multi_engine_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_byte   (in_byte),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_crc   (out_crc),
  .msg_open  (msg_open)
);

// File: tb/crc24_multi_engine_tb.sv
module crc24_multi_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_last = 1'b0;
  logic [2:0]  in_nbits = '0;
  logic [1:0]  poly_sel = '0;
  logic        out_valid;
  logic [23:0] out_crc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] msg [0:31];

  always #5 clk = ~clk;

  crc24_multi_engine dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_nbits(in_nbits), .poly_sel(poly_sel),
    .out_valid(out_valid), .out_crc(out_crc)
  );

  // {sel[1:0], length in bits[13:0], seed[15:0]}
  localparam int NV = 16;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {2'd0, 14'd1,   16'd11}, {2'd0, 14'd7,   16'd23}, {2'd0, 14'd8,   16'd37},
    {2'd0, 14'd9,   16'd41}, {2'd0, 14'd164, 16'd53},
    {2'd1, 14'd1,   16'd61}, {2'd1, 14'd7,   16'd73}, {2'd1, 14'd8,   16'd89},
    {2'd1, 14'd9,   16'd97}, {2'd1, 14'd164, 16'd101},
    {2'd2, 14'd1,   16'd113},{2'd2, 14'd7,   16'd127},{2'd2, 14'd8,   16'd131},
    {2'd2, 14'd9,   16'd149},{2'd2, 14'd164, 16'd157},
    {2'd3, 14'd40,  16'd163}
  };

  function automatic logic [23:0] taps_of(input logic [1:0] s);
    case (s)
      2'd1:    return 24'h800063;
      2'd2:    return 24'hB2B117;
      default: return 24'h864CFB;
    endcase
  endfunction

  // bit-serial reference over the first len bits of msg
  function automatic logic [23:0] ref_crc(input logic [1:0] s, input int len);
    logic [23:0] r = '0;
    logic [23:0] t = taps_of(s);
    for (int i = 0; i < len; i++) begin
      logic b  = msg[i/8][7-(i%8)];
      logic fb = r[23] ^ b;
      r = {r[22:0], 1'b0} ^ (fb ? t : 24'h0);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    logic [31:0] x = 32'(seed);
    for (int i = 0; i < 32; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      msg[i] = x[23:16];
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_nbits = '0;
  endtask

  // sends msg[], garble alters low bits past the end, counts on non-last
  // bytes and the select after the first byte; returns the expected CRC
  task automatic send(input logic [1:0] sel, input int len, input bit garble,
                      input logic [1:0] alt_sel, output logic [23:0] exp);
    int nb  = (len + 7) / 8;
    int rem = len % 8;
    exp = ref_crc(sel, len);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_last  = (i == nb - 1);
      in_byte  = msg[i];
      if (in_last && rem != 0 && garble) in_byte = msg[i] | (8'hFF >> rem);
      in_nbits = in_last ? 3'(rem) : (garble ? 3'(i + 3) : 3'd0);
      poly_sel = (i == 0 || !garble) ? sel : alt_sel;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] e, e2, held;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset out_valid", 32'(out_valid), 32'd0);
    chk("R10 reset out_crc", 32'(out_crc), 32'd0);
    @(negedge clk); rst = 1'b0;

    // vector table: R1/R2/R3 per select; lengths cover R5 and R6
    for (int v = 0; v < NV; v++) begin
      logic [1:0] s = VEC[v][31:30];
      int len = int'(VEC[v][29:16]);
      fill(int'(VEC[v][15:0]));
      send(s, len, 1'b0, 2'd0, e);
      chk("R9 done strobe", 32'(out_valid), 32'd1);
      case (s)
        2'd1:    chk("R2 crc B", 32'(out_crc), 32'(e));
        2'd2:    chk("R3 crc C", 32'(out_crc), 32'(e));
        default: chk("R1 crc A", 32'(out_crc), 32'(e));
      endcase
      held = out_crc;
      idle();
      @(posedge clk); #1;
      chk("R9 strobe one cycle", 32'(out_valid), 32'd0);
      chk("R9 crc held", 32'(out_crc), 32'(held));
    end

    // R4/R1: single 1 bit gives the taps word, zero byte gives zero
    msg[0] = 8'h80;
    send(2'd0, 1, 1'b0, 2'd0, e);
    chk("R1 single bit", 32'(out_crc), 32'h864CFB);
    idle();
    msg[0] = 8'h00;
    send(2'd2, 8, 1'b0, 2'd0, e);
    chk("R4 zero message", 32'(out_crc), 32'h0);
    idle();

    // R5: junk below the valid bits of a partial last byte
    fill(777);
    send(2'd1, 13, 1'b1, 2'd1, e);
    chk("R5 partial last byte", 32'(out_crc), 32'(e));
    idle();

    // R6: full last byte sent with count 0
    fill(888);
    send(2'd2, 24, 1'b0, 2'd0, e);
    chk("R6 count zero is eight", 32'(out_crc), 32'(e));
    idle();

    // R7: nonzero counts on middle bytes
    fill(999);
    send(2'd0, 32, 1'b1, 2'd0, e);
    chk("R7 middle count ignored", 32'(out_crc), 32'(e));
    idle();

    // R8: select changes after the first byte
    fill(4242);
    send(2'd2, 50, 1'b1, 2'd1, e);
    chk("R8 select held", 32'(out_crc), 32'(e));
    idle();

    // R10: back-to-back messages with no idle cycle
    fill(31);
    send(2'd1, 20, 1'b0, 2'd0, e);
    chk("R10 first of pair", 32'(out_crc), 32'(e));
    fill(57);
    send(2'd0, 17, 1'b0, 2'd0, e2);
    chk("R10 second of pair", 32'(out_crc), 32'(e2));
    chk("R10 second strobe", 32'(out_valid), 32'd1);
    idle();

    // R10: reset mid-message clears state
    fill(5);
    @(negedge clk);
    in_valid = 1'b1; in_last = 1'b0; in_byte = 8'hA5; poly_sel = 2'd1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    chk("R10 reset clears crc", 32'(out_crc), 32'd0);
    @(negedge clk); rst = 1'b0;
    send(2'd2, 9, 1'b0, 2'd0, e);
    chk("R10 clean after reset", 32'(out_crc), 32'(e));
    idle();

    repeat (2) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule